// File: doc/BRIEF.md
# Byte-Wide Stack Access Sequencer

This block moves 16-bit words between a processor core and a stack held in byte-wide memory. It owns the 16-bit stack pointer and turns a single start command into the ordered series of byte reads and writes that a push, a pop, a subroutine call, a subroutine return, a top-of-stack exchange or a pointer load needs. The core supplies an operation code and a 16-bit operand, then waits for a one-cycle done pulse. After a pop, return or exchange, the 16-bit value taken from the stack is on the read-value output.

The memory port has one address, one write-data byte, one read-data byte and separate read and write strobes. Read data must come back on the clock after the read strobe. The pointer always moves down before each byte is stored and up after each byte is fetched. An exchange swaps two stack bytes without moving the pointer. In the word convention, the first register of each pair (B, D, H or the accumulator) is the high byte and its partner (C, E, L or the flag byte) is the low byte. The call and return codes carry the return address in the same way.

Top module: `stk_seq_top`

## Requirements
- R1: After synchronous reset the pointer equals the parameter SP_INIT (default 16'h0000), done is low, both strobes are low and the read value is 16'h0000.
- R2: Push (code 0) writes operand bits 15:8 at pointer-1, then writes bits 7:0 at pointer-2. The pointer ends 2 lower and done is high on the 3rd cycle after the start edge.
- R3: Pop (code 1) reads the low byte at the pointer, then the high byte at pointer+1. The read value becomes {high, low}, the pointer ends 2 higher, and done is high on the 4th cycle after the start edge.
- R4: Call (code 2) stores the operand, which is the return address, in the same order and with the same timing as push. Return (code 3) loads a value with the same order and timing as pop.
- R5: Exchange (code 4) reads the bytes at pointer and pointer+1 into the read value, where the byte at the pointer is the low byte. It then writes operand bits 7:0 to the pointer and bits 15:8 to pointer+1. The pointer does not change, and done is high on the 5th cycle.
- R6: Load pointer (code 5) sets the pointer to the operand with no memory access, and done is high on the 2nd cycle.
- R7: All pointer and address arithmetic wraps modulo 65536.
- R8: Done is high for exactly one cycle per accepted command.
- R9: A start that arrives while a command is in progress is ignored. It does not change the pointer, the memory or the number of done pulses.
- R10: The read and write strobes are never high in the same cycle, and neither is high while the sequencer is idle.
- R11: Codes 6 and 7 cause no memory access and no pointer change, and done is high on the 1st cycle after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request, sampled only when idle |
| op_code | input | 3 | Operation code (0 push, 1 pop, 2 call, 3 return, 4 exchange, 5 load pointer) |
| wr_val | input | 16 | Operand word: register pair, return address or new pointer |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid one cycle after mem_rd |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| done | output | 1 | One-cycle completion pulse |
| rd_val | output | 16 | Word fetched by the last pop, return or exchange |
| sp_val | output | 16 | Current stack pointer |

## Verification
The assertions assume that the memory returns read data exactly one cycle after the read strobe and that op_code and wr_val are meaningful only in the cycle in which start is accepted. The bench memory model answers every read on the next edge. The bench drives start for a single cycle, holding it high for no longer than that. The only exception is the directed case that pulses start in the middle of a push. There the assertions expect the latched command to stay unchanged.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int ADDR_W = WORD_W;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_XCHG = 3'd4,
        OP_LDSP = 3'd5
    } stk_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WR_HI,
        S_WR_LO,
        S_RD_LO,
        S_RD_HI,
        S_CAP,
        S_XW_LO,
        S_XW_HI,
        S_LDSP,
        S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        PC_HOLD,
        PC_INC,
        PC_DEC,
        PC_LOAD
    } ptr_cmd_e;

    typedef enum logic [1:0] {
        AS_SP,
        AS_SP_M1,
        AS_SP_P1
    } addr_sel_e;

    typedef enum logic [1:0] {
        CAP_NONE,
        CAP_LO,
        CAP_HI
    } cap_sel_e;

    typedef struct packed {
        ptr_cmd_e  ptr_cmd;
        addr_sel_e addr_sel;
        logic      wr_hi;
        logic      rd;
        logic      wr;
        cap_sel_e  cap;
        logic      done;
    } seq_ctl_t;

    function automatic logic [BYTE_W-1:0] hi_byte(input logic [WORD_W-1:0] w);
        return w[WORD_W-1:BYTE_W];
    endfunction

    function automatic logic [BYTE_W-1:0] lo_byte(input logic [WORD_W-1:0] w);
        return w[BYTE_W-1:0];
    endfunction

    function automatic logic is_store(input logic [OP_W-1:0] o);
        return (o == OP_PUSH) || (o == OP_CALL);
    endfunction

    function automatic logic is_load(input logic [OP_W-1:0] o);
        return (o == OP_POP) || (o == OP_RET);
    endfunction

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr
    import stk_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SP_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  ptr_cmd_e          cmd,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] sp,
    output logic [ADDR_W-1:0] sp_m1,
    output logic [ADDR_W-1:0] sp_p1
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    assign sp_m1 = sp - ONE;
    assign sp_p1 = sp + ONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= SP_INIT;
        end else begin
            unique case (cmd)
                PC_INC:  sp <= sp_p1;
                PC_DEC:  sp <= sp_m1;
                PC_LOAD: sp <= load_val;
                default: sp <= sp;
            endcase
        end
    end

    // R7: stepping down from zero lands on the all-ones address
    p_wrap_down_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd == PC_DEC && sp == '0) |=> (sp == '1));

    // R7: stepping up from all ones lands on zero
    p_wrap_up_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd == PC_INC && sp == '1) |=> (sp == '0));

endmodule

// File: rtl/stk_capture.sv
module stk_capture
    import stk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cap_sel_e          cap_req,
    input  logic [BYTE_W-1:0] rdata,
    output logic [WORD_W-1:0] word
);

    cap_sel_e pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= CAP_NONE;
            word   <= '0;
        end else begin
            pend_q <= cap_req;
            unique case (pend_q)
                CAP_LO:  word[BYTE_W-1:0]      <= rdata;
                CAP_HI:  word[WORD_W-1:BYTE_W] <= rdata;
                default: word                  <= word;
            endcase
        end
    end

    // R3: the low half is filled before the high half of the same word
    p_lo_before_hi_r3: assert property (@(posedge clk) disable iff (rst)
        (cap_req == CAP_HI) |-> (pend_q == CAP_LO));

endmodule

// File: rtl/stk_fsm.sv
module stk_fsm
    import stk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   op_in,
    input  logic [WORD_W-1:0] val_in,
    output seq_state_e        state,
    output logic [OP_W-1:0]   op_q,
    output logic [WORD_W-1:0] val_q,
    output seq_ctl_t          ctl
);

    seq_state_e nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            op_q  <= '0;
            val_q <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && start) begin
                op_q  <= op_in;
                val_q <= val_in;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    if (is_store(op_in))                         nxt = S_WR_HI;
                    else if (is_load(op_in) || op_in == OP_XCHG) nxt = S_RD_LO;
                    else if (op_in == OP_LDSP)                   nxt = S_LDSP;
                    else                                         nxt = S_DONE;
                end
            end
            S_WR_HI: nxt = S_WR_LO;
            S_WR_LO: nxt = S_DONE;
            S_RD_LO: nxt = S_RD_HI;
            S_RD_HI: nxt = (op_q == OP_XCHG) ? S_XW_LO : S_CAP;
            S_CAP:   nxt = S_DONE;
            S_XW_LO: nxt = S_XW_HI;
            S_XW_HI: nxt = S_DONE;
            S_LDSP:  nxt = S_DONE;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        ctl = '{ptr_cmd: PC_HOLD, addr_sel: AS_SP, wr_hi: 1'b0,
                rd: 1'b0, wr: 1'b0, cap: CAP_NONE, done: 1'b0};
        unique case (state)
            S_WR_HI: begin
                ctl.wr       = 1'b1;
                ctl.wr_hi    = 1'b1;
                ctl.addr_sel = AS_SP_M1;
                ctl.ptr_cmd  = PC_DEC;
            end
            S_WR_LO: begin
                ctl.wr       = 1'b1;
                ctl.addr_sel = AS_SP_M1;
                ctl.ptr_cmd  = PC_DEC;
            end
            S_RD_LO: begin
                ctl.rd      = 1'b1;
                ctl.cap     = CAP_LO;
                ctl.ptr_cmd = (op_q == OP_XCHG) ? PC_HOLD : PC_INC;
            end
            S_RD_HI: begin
                ctl.rd       = 1'b1;
                ctl.cap      = CAP_HI;
                ctl.addr_sel = (op_q == OP_XCHG) ? AS_SP_P1 : AS_SP;
                ctl.ptr_cmd  = (op_q == OP_XCHG) ? PC_HOLD : PC_INC;
            end
            S_XW_LO: begin
                ctl.wr = 1'b1;
            end
            S_XW_HI: begin
                ctl.wr       = 1'b1;
                ctl.wr_hi    = 1'b1;
                ctl.addr_sel = AS_SP_P1;
            end
            S_LDSP:  ctl.ptr_cmd = PC_LOAD;
            S_DONE:  ctl.done    = 1'b1;
            default: ;
        endcase
    end

    // R9: a start seen while busy leaves the latched command untouched
    p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && start) |=> ($stable(op_q) && $stable(val_q)));

    // R8: completion never lasts two cycles
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        ctl.done |=> !ctl.done);

endmodule

// File: rtl/stk_seq_top.sv
module stk_seq_top
    import stk_pkg::*;
#(
    parameter logic [15:0] SP_INIT = 16'h0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [2:0]  op_code,
    input  logic [15:0] wr_val,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic        done,
    output logic [15:0] rd_val,
    output logic [15:0] sp_val
);

    seq_state_e        state;
    logic [OP_W-1:0]   op_q;
    logic [WORD_W-1:0] val_q;
    seq_ctl_t          ctl;
    logic [ADDR_W-1:0] sp, sp_m1, sp_p1;

    stk_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .op_in  (op_code),
        .val_in (wr_val),
        .state  (state),
        .op_q   (op_q),
        .val_q  (val_q),
        .ctl    (ctl)
    );

    stk_ptr #(.SP_INIT(SP_INIT)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .cmd      (ctl.ptr_cmd),
        .load_val (val_q),
        .sp       (sp),
        .sp_m1    (sp_m1),
        .sp_p1    (sp_p1)
    );

    stk_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .cap_req (ctl.cap),
        .rdata   (mem_rdata),
        .word    (rd_val)
    );

    always_comb begin
        unique case (ctl.addr_sel)
            AS_SP_M1: mem_addr = sp_m1;
            AS_SP_P1: mem_addr = sp_p1;
            default:  mem_addr = sp;
        endcase
    end

    assign mem_wdata = ctl.wr_hi ? hi_byte(val_q) : lo_byte(val_q);
    assign mem_rd    = ctl.rd;
    assign mem_wr    = ctl.wr;
    assign done      = ctl.done;
    assign sp_val    = sp;

    // R10: one strobe at a time
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R10: an idle sequencer keeps the memory port quiet
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) |-> (!mem_rd && !mem_wr));

    // R3: each fetch of a pop or return advances the pointer by one
    p_pop_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && is_load(op_q)) |=> (sp_val == $past(sp_val) + 16'd1));

    // R2: each store of a push or call goes one below the current pointer
    p_push_below_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && is_store(op_q)) |-> (mem_addr == sp_val - 16'd1));

    // R5: an exchange never moves the pointer
    p_xchg_still_r5: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && state != S_DONE && op_q == OP_XCHG) |=> $stable(sp_val));

endmodule

// File: tb/stk_seq_top_test.sv
`timescale 1ns/1ps
module stk_seq_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op_code = '0;
    logic [15:0] wr_val = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_rd, mem_wr, done;
    logic [15:0] rd_val, sp_val;

    logic [7:0]  mem [256];

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    stk_seq_top uut (
        .clk(clk), .rst(rst), .start(start), .op_code(op_code), .wr_val(wr_val),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .done(done), .rd_val(rd_val), .sp_val(sp_val)
    );

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] val;
        logic [15:0] sp;
        logic [15:0] rv;
        logic        chk_rv;
        logic [3:0]  cyc;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{3'd5, 16'h2080, 16'h2080, 16'h0000, 1'b0, 4'd2},  // R6 load pointer
        '{3'd0, 16'hA1B2, 16'h207E, 16'h0000, 1'b0, 4'd3},  // R2 push
        '{3'd2, 16'h1234, 16'h207C, 16'h0000, 1'b0, 4'd3},  // R4 call
        '{3'd4, 16'h5566, 16'h207C, 16'h1234, 1'b1, 4'd5},  // R5 exchange
        '{3'd3, 16'h0000, 16'h207E, 16'h5566, 1'b1, 4'd4},  // R4 return
        '{3'd1, 16'h0000, 16'h2080, 16'hA1B2, 1'b1, 4'd4}   // R3 pop
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] o, input logic [15:0] v, output int cyc);
        @(negedge clk);
        start = 1'b1; op_code = o; wr_val = v;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic after_done_low(input string req);
        @(negedge clk);
        check(done == 1'b0, req, {31'd0, done}, 32'd0);
    endtask

    initial begin
        int cyc;
        logic [15:0] sp_hold;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(sp_val == 16'h0000, "R1 sp", {16'd0, sp_val}, 32'h0);
        check(!done && !mem_rd && !mem_wr, "R1 outputs", {29'd0, done, mem_rd, mem_wr}, 32'd0);
        check(rd_val == 16'h0000, "R1 rd_val", {16'd0, rd_val}, 32'h0);
        rst = 1'b0;

        for (int k = 0; k < 6; k++) begin
            run_op(VEC[k].op, VEC[k].val, cyc);
            check(cyc == int'(VEC[k].cyc), "R2/R3/R4/R5/R6 latency", cyc, VEC[k].cyc);
            check(sp_val == VEC[k].sp, "R2/R3/R4/R5/R6 pointer", sp_val, VEC[k].sp);
            if (VEC[k].chk_rv)
                check(rd_val == VEC[k].rv, "R3/R4/R5 read value", rd_val, VEC[k].rv);
            after_done_low("R8 single pulse");
        end
        check(mem[8'h7F] == 8'hA1, "R2 high byte at sp-1", mem[8'h7F], 8'hA1);
        check(mem[8'h7E] == 8'hB2, "R2 low byte at sp-2", mem[8'h7E], 8'hB2);
        check(mem[8'h7C] == 8'h66, "R5 low written at sp", mem[8'h7C], 8'h66);
        check(mem[8'h7D] == 8'h55, "R5 high written at sp+1", mem[8'h7D], 8'h55);

        // R7 push wrapping below zero
        run_op(3'd5, 16'h0000, cyc);
        run_op(3'd0, 16'hCAFE, cyc);
        check(sp_val == 16'hFFFE, "R7 push wrap pointer", sp_val, 16'hFFFE);
        check(mem[8'hFF] == 8'hCA && mem[8'hFE] == 8'hFE, "R7 push wrap bytes",
              {mem[8'hFF], mem[8'hFE]}, 16'hCAFE);

        // R7 pop wrapping past all ones
        mem[8'hFF] = 8'h11; mem[8'h00] = 8'h22;
        run_op(3'd5, 16'hFFFF, cyc);
        run_op(3'd1, 16'h0000, cyc);
        check(rd_val == 16'h2211, "R7 pop wrap value", rd_val, 16'h2211);
        check(sp_val == 16'h0001, "R7 pop wrap pointer", sp_val, 16'h0001);

        // R7 exchange straddling the wrap point
        run_op(3'd5, 16'hFFFF, cyc);
        run_op(3'd4, 16'h3344, cyc);
        check(rd_val == 16'h2211, "R7 exchange wrap read", rd_val, 16'h2211);
        check(mem[8'hFF] == 8'h44 && mem[8'h00] == 8'h33, "R7 exchange wrap write",
              {mem[8'h00], mem[8'hFF]}, 16'h3344);
        check(sp_val == 16'hFFFF, "R5 exchange keeps pointer", sp_val, 16'hFFFF);

        // R11 unused code
        run_op(3'd6, 16'h9999, cyc);
        check(cyc == 1, "R11 latency", cyc, 1);
        check(sp_val == 16'hFFFF, "R11 pointer unchanged", sp_val, 16'hFFFF);

        // R9 start while busy is ignored
        run_op(3'd5, 16'h4010, cyc);
        @(negedge clk);
        start = 1'b1; op_code = 3'd0; wr_val = 16'h7788;
        @(negedge clk);
        start = 1'b1; op_code = 3'd5; wr_val = 16'h0000;
        @(negedge clk);
        start = 1'b0;
        cyc = 2;
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == 3, "R9 latency unchanged", cyc, 3);
        check(sp_val == 16'h400E, "R9 pointer after push", sp_val, 16'h400E);
        sp_hold = sp_val;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            check(!done && !mem_rd && !mem_wr, "R9 no second command",
                  {29'd0, done, mem_rd, mem_wr}, 32'd0);
        end
        check(sp_val == sp_hold, "R9 pointer stable", sp_val, sp_hold);
        check(mem[8'h0F] == 8'h77 && mem[8'h0E] == 8'h88, "R9 push bytes",
              {mem[8'h0F], mem[8'h0E]}, 16'h7788);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule